// File: doc/BRIEF.md
# Hardware-Monitor Interrupt Status Registers

This block keeps the sticky status bits for limit-violation and fault events that a hardware-monitor sequencer reports. The sequencer supplies two vectors, one bit per event. One vector is a level that says whether the event's condition is present right now. The other is a one-cycle pulse that says the event was detected during the current conversion pass. A detected event whose enable bit is set latches into two copies of the status bit at once: one in a primary register pair and one in a secondary register pair.

Software uses a simple register port to read the status. It writes ones to request that bits be cleared, and it programs the enable bits. A clear request only succeeds for a bit whose source condition has gone away. The active-low interrupt output reflects the primary pair only, so the secondary pair can be used for polling without touching the interrupt line.

Top module: `hwmon_irq_status`

## Requirements
- R1: A pulse on `evt_hit` bit `8*r+k` while enable register r bit k is 1 sets bit k of primary register r and of secondary register r on that clock edge.
- R2: A pulse on an event whose enable bit is 0 leaves both status registers unchanged.
- R3: A set status bit stays set across any number of cycles without a clearing write.
- R4: Writing 1 to a status bit while its `evt_active` bit is 1 leaves the bit set. Writing 1 while `evt_active` is 0 clears it.
- R5: Writing 0 to a status bit has no effect, and each bit of a register is cleared independently of the other bits.
- R6: When a qualified event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: `rst_n` low clears all status and enable registers to 0x00. A one-cycle `init` high clears all status registers and leaves the enables unchanged.
- R8: `irq_n` is 0 while any bit of the two primary registers is 1, and is 1 when both are 0x00.
- R9: The contents of the secondary registers have no effect on `irq_n`, and clearing a primary bit does not clear its secondary copy.
- R10: The register map is: primary 0x41/0x42, secondary 0xA5/0xA6, and enables 0x50/0x51 (read/write). Register r covers event bits `8*r` to `8*r+7`. Reads of any other address return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous clear of all status registers |
| addr | input | 8 | Register address for read and write |
| wr_en | input | 1 | Write strobe for one cycle |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| evt_active | input | 16 | Level per event: condition present now |
| evt_hit | input | 16 | One-cycle pulse per event: detected this pass |
| irq_n | output | 1 | Active-low interrupt from the primary registers |

## Verification
The bench builds the block with its defaults: 8-bit registers, two registers per set, and the map given in R10. Two registers per set are enough to show several things at the port. `irq_n` stays asserted while one primary register is cleared and the other is still set. An event on the upper register is gated by that register's own enable. A cleared primary register leaves its secondary copy set.

// File: rtl/hwmon_irq_status.sv
module hwmon_irq_status #(
  parameter int W = 8,
  parameter int NREG = 2,
  parameter logic [7:0] PRI_BASE = 8'h41,
  parameter logic [7:0] SEC_BASE = 8'hA5,
  parameter logic [7:0] ENA_BASE = 8'h50,
  localparam int N = W * NREG
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         init,
  input  logic [7:0]   addr,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  input  logic [N-1:0] evt_active,
  input  logic [N-1:0] evt_hit,
  output logic         irq_n
);

  logic [N-1:0] pri_q, sec_q, ena_q;
  logic [N-1:0] pri_d, sec_d, ena_d;
  logic [N-1:0] qual_hit;
  logic         pri_wr_any;

  assign qual_hit = evt_hit & ena_q;

  always_comb begin
    pri_d = pri_q;
    sec_d = sec_q;
    ena_d = ena_q;
    pri_wr_any = 1'b0;
    rdata = '0;
    for (int r = 0; r < NREG; r++) begin
      if (addr == PRI_BASE + 8'(r)) begin
        rdata = pri_q[r*W +: W];
        if (wr_en) begin
          pri_wr_any = 1'b1;
          pri_d[r*W +: W] = pri_q[r*W +: W] & ~(wdata & ~evt_active[r*W +: W]);
        end
      end
      if (addr == SEC_BASE + 8'(r)) begin
        rdata = sec_q[r*W +: W];
        if (wr_en)
          sec_d[r*W +: W] = sec_q[r*W +: W] & ~(wdata & ~evt_active[r*W +: W]);
      end
      if (addr == ENA_BASE + 8'(r)) begin
        rdata = ena_q[r*W +: W];
        if (wr_en) ena_d[r*W +: W] = wdata;
      end
    end
    pri_d = pri_d | qual_hit;
    sec_d = sec_d | qual_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri_q <= '0;
      sec_q <= '0;
      ena_q <= '0;
    end else begin
      ena_q <= ena_d;
      if (init) begin
        pri_q <= '0;
        sec_q <= '0;
      end else begin
        pri_q <= pri_d;
        sec_q <= sec_d;
      end
    end
  end

  assign irq_n = ~|pri_q;

  // R1 R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> ((pri_q & sec_q & $past(qual_hit)) == $past(qual_hit)));

  // R2
  gated_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((pri_q & ~$past(pri_q)) & ~$past(evt_hit & ena_q)) == '0));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init |=> ((($past(pri_q) & $past(evt_active)) & ~pri_q) == '0));

  // R3
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !pri_wr_any) |=> (($past(pri_q) & ~pri_q) == '0));

endmodule

// File: tb/hwmon_irq_status_test.sv
module hwmon_irq_status_test;
  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, wr_en = 1'b0;
  logic [7:0] addr = 8'h00, wdata = 8'h00, rdata;
  logic [15:0] evt_active = '0, evt_hit = '0;
  logic irq_n;
  int n_chk = 0, n_ok = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hwmon_irq_status uut (.clk(clk), .rst_n(rst_n), .init(init), .addr(addr),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .evt_active(evt_active),
    .evt_hit(evt_hit), .irq_n(irq_n));

  typedef struct packed {
    logic       we;
    logic [7:0] a;
    logic [7:0] d;
    logic [15:0] act;
    logic [15:0] hit;
    logic [7:0] ra;
    logic [7:0] rexp;
    logic       iexp;
    logic [3:0] req;
  } vec_t;

  localparam vec_t TBL [11] = '{
    '{1'b1, 8'h50, 8'hFF, 16'h0000, 16'h0000, 8'h50, 8'hFF, 1'b1, 4'd10}, // R10 enable write
    '{1'b1, 8'h51, 8'h0F, 16'h0000, 16'h0000, 8'h51, 8'h0F, 1'b1, 4'd10},
    '{1'b0, 8'h00, 8'h00, 16'h0001, 16'h0001, 8'h41, 8'h01, 1'b0, 4'd1},  // R1 primary
    '{1'b0, 8'h00, 8'h00, 16'h0001, 16'h1100, 8'h42, 8'h01, 1'b0, 4'd2},  // R2 bit4 disabled
    '{1'b0, 8'h00, 8'h00, 16'h0001, 16'h0000, 8'hA5, 8'h01, 1'b0, 4'd1},  // R1 secondary
    '{1'b1, 8'h41, 8'h01, 16'h0001, 16'h0000, 8'h41, 8'h01, 1'b0, 4'd4},  // R4 blocked
    '{1'b1, 8'h41, 8'h00, 16'h0000, 16'h0000, 8'h41, 8'h01, 1'b0, 4'd5},  // R5 write 0
    '{1'b1, 8'h41, 8'h01, 16'h0000, 16'h0000, 8'h41, 8'h00, 1'b0, 4'd8},  // R4/R8 42h holds irq
    '{1'b1, 8'h42, 8'hFF, 16'h0000, 16'h0000, 8'h42, 8'h00, 1'b1, 4'd8},  // R8 release
    '{1'b0, 8'h00, 8'h00, 16'h0000, 16'h0000, 8'hA6, 8'h01, 1'b1, 4'd9},  // R9 secondary kept
    '{1'b1, 8'hA5, 8'h01, 16'h0000, 16'h0000, 8'hA5, 8'h00, 1'b1, 4'd9}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act === exp) n_ok++;
    else $display("FAIL %s actual=%h expected=%h", req, act, exp);
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [7:0] d,
                      input logic [15:0] act, input logic [15:0] hit);
    @(negedge clk);
    wr_en = we; addr = a; wdata = d; evt_active = act; evt_hit = hit;
    @(negedge clk);
    wr_en = 1'b0; evt_hit = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_ok, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R7 reset state
    rd("R7", 8'h41, 8'h00);
    rd("R7", 8'hA6, 8'h00);
    rd("R7", 8'h50, 8'h00);
    check("R8", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;

    for (int i = 0; i < 11; i++) begin
      step(TBL[i].we, TBL[i].a, TBL[i].d, TBL[i].act, TBL[i].hit);
      rd($sformatf("R%0d step %0d", TBL[i].req, i), TBL[i].ra, TBL[i].rexp);
      check($sformatf("R%0d irq step %0d", TBL[i].req, i), {7'd0, irq_n}, {7'd0, TBL[i].iexp});
    end

    // R6 set beats clear on the same bit
    step(1'b1, 8'h41, 8'h02, 16'h0000, 16'h0002);
    rd("R6", 8'h41, 8'h02);
    check("R8", {7'd0, irq_n}, 8'h00);

    // R5 independent bit clear
    step(1'b0, 8'h00, 8'h00, 16'h0000, 16'h0004);
    rd("R5", 8'h41, 8'h06);
    step(1'b1, 8'h41, 8'h04, 16'h0000, 16'h0000);
    rd("R5", 8'h41, 8'h02);

    // R3 sticky over idle cycles
    repeat (5) step(1'b0, 8'h00, 8'h00, 16'h0000, 16'h0000);
    rd("R3", 8'h41, 8'h02);

    // R7 init clears status, keeps enables
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    rd("R7", 8'h41, 8'h00);
    rd("R7", 8'hA5, 8'h00);
    rd("R7", 8'h50, 8'hFF);
    check("R7", {7'd0, irq_n}, 8'h01);

    // R10 unmapped address
    rd("R10", 8'h60, 8'h00);

    // R7 reset clears enables
    rst_n = 1'b0;
    #1;
    rd("R7", 8'h51, 8'h00);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_ok, n_chk);
    $finish;
  end
endmodule